// File: doc/BRIEF.md
# Token-Ring Deep FIFO Controller

This block joins several identical FIFO slices so that together they act as one deeper FIFO. Two tokens travel around a ring of slices, one for writes and one for reads. A slice stores incoming words only while it owns the write token. It returns words only while it owns the read token. When a slice has used its last location on one side, it sends a one-cycle pulse on that side's cascade wire to the next slice in the ring and gives up the token. The slice that receives the pulse takes the token and starts at location zero. The cascade output of the highest slice feeds slice zero, which closes the ring. The slices need no glue logic between them.

A strap per slice, active low, picks the slice that loads first. That slice owns both tokens when reset ends. All other slices ignore requests until a token reaches them. The top level is a model of a ring of `NUM_SLICES` slices with a simplified storage array in each slice. Both token sides run on one clock.

Data enters on a valid/ready stream. A word is taken on a clock edge only when `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. Data leaves on a second valid/ready stream. A word is consumed when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. The overall full flag is the full flag of the slice that owns the write token. The overall empty flag is the empty flag of the slice that owns the read token.

Top module: `fifo_token_ring`

## Requirements
- R1: While reset is held and after it is released, the slice whose bit of `first_load_n` is 0 owns both tokens. Bit i of `wr_token` and `rd_token` stands for slice i. The ring is empty: `empty`=1, `full`=0, `out_valid`=0 and `in_ready`=1.
- R2: A word is stored only in the slice that owns the write token. `in_ready` is 1 exactly when that slice is not full, so the ring accepts words up to `NUM_SLICES*SLICE_DEPTH` entries.
- R3: After `SLICE_DEPTH` writes into a slice, the write token moves to the next slice (index plus one). That slice starts writing at its location zero.
- R4: After `SLICE_DEPTH` reads from a slice, the read token moves to the next slice in the same way. That slice starts reading at its location zero.
- R5: The slice with the highest index passes each token to slice 0.
- R6: A handoff costs no cycle. The receiving slice uses the cascade pulse as its token in the cycle that follows the last access, so `in_ready` and `out_valid` do not drop at a slice boundary. Each cascade pulse lasts exactly one cycle.
- R7: `full` equals the full flag of the slice that owns the write token. While `full` is 1, `in_ready` is 0.
- R8: `empty` equals the empty flag of the slice that owns the read token. `out_valid` is the inverse of `empty`.
- R9: Words come out in the order they went in, including when reads and writes happen in the same cycle. `out_data` stays stable while it is stalled by `out_ready`=0.
- R10: Exactly one slice owns the write token and exactly one slice owns the read token in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both token sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| first_load_n | input | NUM_SLICES | First-load strap per slice, active low. Exactly one bit is 0. |
| in_valid | input | 1 | Write stream: a word is offered |
| in_ready | output | 1 | Write stream: the ring can take a word |
| in_data | input | WIDTH | Write stream data |
| out_valid | output | 1 | Read stream: a word is available |
| out_ready | input | 1 | Read stream: the consumer takes the word |
| out_data | output | WIDTH | Read stream data |
| full | output | 1 | The slice that owns the write token is full |
| empty | output | 1 | The slice that owns the read token is empty |
| wr_token | output | NUM_SLICES | One-hot: which slice owns the write token |
| rd_token | output | NUM_SLICES | One-hot: which slice owns the read token |

## Verification
The hardest case to reach is when the writer comes back into a slice that the reader is still draining. In that case the slice's full flag, not the ring's fill level, decides `in_ready`. To get there, the stimulus fills the ring to capacity, drains part of it, and then refills it with mixed read and write densities. This is repeated for every choice of first-load slice. The expected token positions are computed from the running counts of writes and reads. The expected order of the data comes from a reference queue.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;

  // Status that one slice reports to the ring.
  typedef struct packed {
    logic full;
    logic empty;
  } slice_flags_t;

  // Index of the slice that feeds slice idx in a ring of n slices.
  function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned n);
    return (idx == 0) ? n - 1 : idx - 1;
  endfunction

  // Index of the slice that slice idx feeds in a ring of n slices.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx == n - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/token_side.sv
// One token side of a slice (write or read): holds the token, keeps the
// location pointer, and produces the one-cycle cascade pulse.
module token_side #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_load_n,
  input  logic          casc_in,
  input  logic          req,
  input  logic          blocked,
  output logic          own,
  output logic          fire,
  output logic [AW-1:0] ptr,
  output logic          casc_out
);

  logic tok_q;

  // A pulse arriving on casc_in already counts as the token in this cycle.
  assign own  = tok_q | casc_in;
  assign fire = req & own & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q    <= ~first_load_n;
      ptr      <= '0;
      casc_out <= 1'b0;
    end else begin
      casc_out <= 1'b0;
      if (casc_in) tok_q <= 1'b1;
      if (fire) begin
        if (ptr == AW'(DEPTH - 1)) begin
          ptr      <= '0;
          tok_q    <= 1'b0;
          casc_out <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ring_slice.sv
// One FIFO slice: a write token side, a read token side, an occupancy count
// and a simplified storage array.
module ring_slice
  import fifo_ring_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_casc_in,
  output logic             wr_casc_out,
  output logic             wr_own,
  input  logic             rd_req,
  input  logic             rd_casc_in,
  output logic             rd_casc_out,
  output logic             rd_own,
  output logic [WIDTH-1:0] rd_data,
  output slice_flags_t     flags
);

  logic          wfire, rfire;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] fill;
  logic [WIDTH-1:0] mem [DEPTH];

  assign flags.full  = (fill == CW'(DEPTH));
  assign flags.empty = (fill == '0);

  token_side #(.DEPTH(DEPTH)) u_wside (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
    .casc_in(wr_casc_in), .req(wr_req), .blocked(flags.full),
    .own(wr_own), .fire(wfire), .ptr(wptr), .casc_out(wr_casc_out)
  );

  token_side #(.DEPTH(DEPTH)) u_rside (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
    .casc_in(rd_casc_in), .req(rd_req), .blocked(flags.empty),
    .own(rd_own), .fire(rfire), .ptr(rptr), .casc_out(rd_casc_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (wfire && !rfire) begin
      fill <= fill + 1'b1;
    end else if (rfire && !wfire) begin
      fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wfire) mem[wptr] <= wr_data;
  end

  assign rd_data = mem[rptr];

endmodule

// File: rtl/fifo_token_ring.sv
// A ring of identical slices that act as one deep FIFO by passing tokens.
module fifo_token_ring
  import fifo_ring_pkg::*;
#(
  parameter int unsigned NUM_SLICES  = 4,
  parameter int unsigned SLICE_DEPTH = 4,
  parameter int unsigned WIDTH       = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SLICES-1:0] first_load_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [WIDTH-1:0]      in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WIDTH-1:0]      out_data,
  output logic                  full,
  output logic                  empty,
  output logic [NUM_SLICES-1:0] wr_token,
  output logic [NUM_SLICES-1:0] rd_token
);

  logic [NUM_SLICES-1:0] wcasc, rcasc;
  logic [NUM_SLICES-1:0] full_v, empty_v;
  logic [WIDTH-1:0]      slice_q [NUM_SLICES];
  slice_flags_t          flags_v [NUM_SLICES];

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    localparam int unsigned PREV = ring_prev(i, NUM_SLICES);

    ring_slice #(.DEPTH(SLICE_DEPTH), .WIDTH(WIDTH)) u_slice (
      .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n[i]),
      .wr_req(in_valid), .wr_data(in_data),
      .wr_casc_in(wcasc[PREV]), .wr_casc_out(wcasc[i]), .wr_own(wr_token[i]),
      .rd_req(out_ready),
      .rd_casc_in(rcasc[PREV]), .rd_casc_out(rcasc[i]), .rd_own(rd_token[i]),
      .rd_data(slice_q[i]), .flags(flags_v[i])
    );

    assign full_v[i]  = flags_v[i].full;
    assign empty_v[i] = flags_v[i].empty;
  end

  assign full      = |(wr_token & full_v);
  assign empty     = |(rd_token & empty_v);
  assign in_ready  = |(wr_token & ~full_v);
  assign out_valid = |(rd_token & ~empty_v);

  always_comb begin
    out_data = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      if (rd_token[i]) out_data = out_data | slice_q[i];
    end
  end

endmodule

// File: rtl/fifo_token_ring_chk.sv
module fifo_token_ring_chk
  import fifo_ring_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 4,
  parameter int unsigned WIDTH      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [WIDTH-1:0]      out_data,
  input logic                  full,
  input logic                  empty,
  input logic [NUM_SLICES-1:0] wr_token,
  input logic [NUM_SLICES-1:0] rd_token,
  input logic [NUM_SLICES-1:0] wcasc,
  input logic [NUM_SLICES-1:0] rcasc
);

  // R10
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_token) == 1);

  // R10
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_token) == 1);

  // R7
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);

  // R8
  empty_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !out_valid);

  // R9
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_pulse
    localparam int unsigned NXT = ring_next(i, NUM_SLICES);

    // R6
    wpulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wcasc[i] |=> !wcasc[i]);

    // R6
    rpulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rcasc[i] |=> !rcasc[i]);

    // R3 R5
    whandoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wcasc[i] |-> wr_token[NXT]);

    // R4 R5
    rhandoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rcasc[i] |-> rd_token[NXT]);
  end

endmodule

bind fifo_token_ring fifo_token_ring_chk #(.NUM_SLICES(NUM_SLICES), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .full(full), .empty(empty),
  .wr_token(wr_token), .rd_token(rd_token), .wcasc(wcasc), .rcasc(rcasc)
);

// File: tb/fifo_token_ring_bench.sv
module fifo_token_ring_bench;
  localparam int N   = 4;
  localparam int D   = 4;
  localparam int W   = 8;
  localparam int CAP = N * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] first_load_n = '1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, full, empty;
  logic [W-1:0] out_data;
  logic [N-1:0] wr_token, rd_token;

  int checks = 0, errors = 0, cyc = 0;
  int first = 0, wr_total = 0, rd_total = 0;
  logic [W-1:0] seq = '0;
  logic [W-1:0] model [$];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  fifo_token_ring #(.NUM_SLICES(N), .SLICE_DEPTH(D), .WIDTH(W)) u_fifo_token_ring (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .full(full), .empty(empty), .wr_token(wr_token), .rd_token(rd_token)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int onehot_at(input int idx);
    return 1 << (idx % N);
  endfunction

  task automatic check_outputs();
    int cnt = model.size();
    chk("R2 R6 in_ready", int'(in_ready), int'(cnt < CAP));
    chk("R8 out_valid", int'(out_valid), int'(cnt > 0));
    chk("R7 full", int'(full), int'(cnt == CAP));
    chk("R8 empty", int'(empty), int'(cnt == 0));
    chk("R3 wr_token", int'(wr_token), onehot_at(first + wr_total / D));
    chk("R4 rd_token", int'(rd_token), onehot_at(first + rd_total / D));
    chk("R10 token count", $countones(wr_token) + $countones(rd_token), 2);
    if (cnt > 0) chk("R9 out_data", int'(out_data), int'(model[0]));
  endtask

  task automatic step(input logic v, input logic r);
    logic wf, rf;
    @(negedge clk);
    check_outputs();
    in_valid  = v;
    in_data   = seq;
    out_ready = r;
    wf = v && (model.size() < CAP);
    rf = r && (model.size() > 0);
    @(posedge clk);
    #1;
    if (rf) begin void'(model.pop_front()); rd_total++; end
    if (wf) begin model.push_back(seq); seq++; wr_total++; end
  endtask

  task automatic do_reset(input int sel);
    first = sel; wr_total = 0; rd_total = 0;
    model.delete();
    in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    first_load_n = ~(N'(1) << sel);
    @(negedge clk);
    chk("R1 wr_token in reset", int'(wr_token), onehot_at(sel));
    chk("R1 rd_token in reset", int'(rd_token), onehot_at(sel));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
  endtask

  initial begin
    for (int s = 0; s < N; s++) begin
      do_reset(s);
      // Fill past capacity: the extra attempt must be refused.
      for (int k = 0; k < CAP + 2; k++) step(1'b1, 1'b0);
      chk("R5 write token wrapped to first slice", int'(wr_token), onehot_at(s));
      chk("R2 accepted count", wr_total, CAP);
      // Read and write together while full: only the read proceeds.
      step(1'b1, 1'b1);
      // Partial drain so the writer re-enters a slice being drained.
      for (int k = 0; k < D + 2; k++) step(1'b0, 1'b1);
      for (int k = 0; k < D + 3; k++) step(1'b1, 1'b0);
      // Mixed densities.
      for (int m = 0; m < 4; m++) begin
        for (int k = 0; k < 120; k++) begin
          logic v, r;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          case (m)
            0: begin v = lfsr[0] | lfsr[1]; r = lfsr[2] & lfsr[3]; end
            1: begin v = lfsr[0] & lfsr[1]; r = lfsr[2] | lfsr[3]; end
            2: begin v = lfsr[0];           r = lfsr[5];           end
            default: begin v = 1'b1;        r = 1'b1;              end
          endcase
          step(v, r);
        end
      end
      // Drain everything, one past empty.
      for (int k = 0; k < CAP + 2; k++) step(1'b0, 1'b1);
      chk("R5 R4 read token follows write token", int'(rd_token), int'(wr_token));
      step(1'b0, 1'b0);
    end
    summary();
  end

endmodule